// File: doc/BRIEF.md
# Byte-stream to aligned word write packer

This block turns a byte-addressed write request into a series of aligned word program requests for a word-wide flash programming engine. A request gives a start byte address and a byte count. The payload then arrives one byte at a time on a valid/ready stream. The block packs the payload into words of `LANES` bytes, with a default of 4. Each word goes out with its aligned word address, and the block waits for the engine's pass/fail response before it builds the next word.

Flash can only clear bits while programming, so lanes that carry no payload are filled with the erased byte value 0xFF. This leaves the existing contents of those lanes untouched. This padding covers the lanes below an unaligned start address and the lanes after the last payload byte. No byte enables are used.

The block checks the request range first. A request whose end runs past the device size is rejected, and a request with a zero count completes at once. The block finishes with a one-cycle done pulse that carries an error flag and the number of payload bytes programmed successfully.

Top module: `bytewr_packer`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `in_ready`, `wrd_valid` and `done` are 0.
- R2: A request with `req_len` = 0 is accepted and finishes with a `done` pulse in the cycle after acceptance, with `done_err` = 0 and `done_count` = 0. No word is issued and no byte is taken. A zero count takes priority over the range check.
- R3: A request with `req_addr + req_len > DEV_BYTES` is rejected with `done` in the cycle after acceptance, with `done_err` = 1 and `done_count` = 0. No word is issued and no byte is taken.
- R4: Each word address equals the byte address of the word's first covered byte with its low log2(`LANES`) bits cleared. Successive words of one request rise by `LANES`.
- R5: In the first word of a request with an unaligned start, every lane below the start offset holds 0xFF.
- R6: In a word where the payload runs out before the top lane, every lane above the last payload byte holds 0xFF.
- R7: Packing is little-endian. Lane k, at data bits [8k+7:8k], holds the byte for address `wrd_addr + k`. A fully covered word carries `LANES` consecutive payload bytes.
- R8: `in_ready` is high only while a word is being filled and never while a word is offered or awaits its response. A request never takes more than `req_len` bytes.
- R9: While `wrd_valid` is 1 and `wrd_ready` is 0, `wrd_valid`, `wrd_addr` and `wrd_data` stay unchanged.
- R10: When every word passes, `done_count` equals `req_len` and `done_err` = 0. The count grows only by the payload bytes of each word that passed.
- R11: A fail response (`rsp_fail` = 1 with `rsp_valid`) ends the request: `done_err` = 1, `done_count` = the payload bytes of the words that passed before it, and no further word is issued or byte taken.
- R12: `done` lasts exactly one cycle. `req_ready` is 1 only while idle, never together with `in_ready`, `wrd_valid` or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Payload byte count |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken when valid |
| in_byte | input | 8 | Payload byte |
| wrd_valid | output | 1 | Word program request offered |
| wrd_ready | input | 1 | Engine takes the word |
| wrd_addr | output | ADDR_W | Aligned byte address of the word |
| wrd_data | output | 8*LANES | Packed word, lane 0 in the low byte |
| rsp_valid | input | 1 | Engine result for the last word |
| rsp_fail | input | 1 | Result was a failure |
| done | output | 1 | One-cycle request completion pulse |
| done_err | output | 1 | Request rejected or a word failed |
| done_count | output | LEN_W | Payload bytes programmed successfully |

## Verification
The assertions assume that the engine answers each accepted word with exactly one `rsp_valid` pulse, and never before the word is taken. They also assume that request fields are stable while `req_valid` is high. The bench's response driver sends one pulse per word handshake, after a chosen latency, and raises `req_valid` only while the model knows the block is idle. The byte stream offers exactly the payload bytes and stays valid whenever bytes remain, so any over-consumption shows up as a short queue when the request completes.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FILL  = 3'd1,
      ST_ISSUE = 3'd2,
      ST_WAIT  = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/bwp_range_chk.sv
module bwp_range_chk #(
   parameter int ADDR_W    = 21,
   parameter int LEN_W     = 16,
   parameter int DEV_BYTES = 2097152
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              empty_o,
   output logic              over_o
);
   localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
   localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEV_BYTES);

   logic [SUM_W-1:0] end_sum;

   always_comb begin
      end_sum = SUM_W'(addr_i) + SUM_W'(len_i);
      empty_o = (len_i == '0);
      over_o  = (end_sum > LIMIT);
   end
endmodule

// File: rtl/bwp_lane_fill.sv
module bwp_lane_fill #(
   parameter int         LANES = 4,
   parameter logic [7:0] PAD   = 8'hFF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     wr_en_i,
   input  logic [$clog2(LANES)-1:0] wr_lane_i,
   input  logic [7:0]               wr_byte_i,
   output logic [8*LANES-1:0]       word_o
);
   localparam int LANE_W = $clog2(LANES);

   logic [7:0] lane_q [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[g] <= PAD;
         else if (clear_i)
            lane_q[g] <= PAD;
         else if (wr_en_i && (wr_lane_i == LANE_W'(g)))
            lane_q[g] <= wr_byte_i;
      end
      assign word_o[8*g +: 8] = lane_q[g];
   end
endmodule

// File: rtl/bwp_seq.sv
module bwp_seq
   import bwp_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int LEN_W  = 16,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LEN_W-1:0]         req_len,
   input  logic                     range_empty,
   input  logic                     range_over,
   input  logic                     in_valid,
   input  logic                     wrd_ready,
   input  logic                     rsp_valid,
   input  logic                     rsp_fail,
   output logic                     req_ready,
   output logic                     in_ready,
   output logic                     wrd_valid,
   output logic [ADDR_W-1:0]        wrd_addr,
   output logic                     fill_clear,
   output logic                     fill_wr,
   output logic [$clog2(LANES)-1:0] fill_lane,
   output logic                     done,
   output logic                     done_err,
   output logic [LEN_W-1:0]         done_count
);
   localparam int LANE_W = $clog2(LANES);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LANES);

   seq_state_t          state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [LANE_W-1:0]   lane_q;
   logic [LEN_W-1:0]    remain_q;
   logic [LEN_W-1:0]    total_q;
   logic [LANE_W:0]     nreal_q;
   logic                err_q;

   logic take_byte, last_byte, start_ok, rsp_ok, more_words;

   always_comb begin
      take_byte  = (state_q == ST_FILL) && in_valid;
      last_byte  = (lane_q == LANE_W'(LANES - 1)) || (remain_q == LEN_W'(1));
      start_ok   = (state_q == ST_IDLE) && req_valid && !range_empty && !range_over;
      rsp_ok     = (state_q == ST_WAIT) && rsp_valid && !rsp_fail;
      more_words = rsp_ok && (remain_q != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         lane_q   <= '0;
         remain_q <= '0;
         total_q  <= '0;
         nreal_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  total_q <= '0;
                  nreal_q <= '0;
                  err_q   <= range_over && !range_empty;
                  if (range_empty || range_over) begin
                     state_q <= ST_DONE;
                  end else begin
                     addr_q   <= {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                     lane_q   <= req_addr[LANE_W-1:0];
                     remain_q <= req_len;
                     state_q  <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (in_valid) begin
                  lane_q   <= lane_q + LANE_W'(1);
                  remain_q <= remain_q - LEN_W'(1);
                  nreal_q  <= nreal_q + (LANE_W+1)'(1);
                  if (last_byte)
                     state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (wrd_ready)
                  state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_fail) begin
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     total_q <= total_q + LEN_W'(nreal_q);
                     if (remain_q == '0) begin
                        state_q <= ST_DONE;
                     end else begin
                        addr_q  <= addr_q + STRIDE;
                        lane_q  <= '0;
                        nreal_q <= '0;
                        state_q <= ST_FILL;
                     end
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (state_q == ST_IDLE);
      in_ready   = (state_q == ST_FILL);
      wrd_valid  = (state_q == ST_ISSUE);
      wrd_addr   = addr_q;
      fill_clear = start_ok || more_words;
      fill_wr    = take_byte;
      fill_lane  = lane_q;
      done       = (state_q == ST_DONE);
      done_err   = err_q;
      done_count = total_q;
   end
endmodule

// File: rtl/bytewr_packer.sv
module bytewr_packer #(
   parameter int         ADDR_W    = 21,
   parameter int         LEN_W     = 16,
   parameter int         LANES     = 4,
   parameter int         DEV_BYTES = 2097152,
   parameter logic [7:0] PAD       = 8'hFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [7:0]           in_byte,
   output logic                 wrd_valid,
   input  logic                 wrd_ready,
   output logic [ADDR_W-1:0]    wrd_addr,
   output logic [8*LANES-1:0]   wrd_data,
   input  logic                 rsp_valid,
   input  logic                 rsp_fail,
   output logic                 done,
   output logic                 done_err,
   output logic [LEN_W-1:0]     done_count
);
   localparam int LANE_W = $clog2(LANES);

   if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("bytewr_packer: LANES must be a power of two of at least 2");
   end
   if (ADDR_W <= LANE_W || ADDR_W > 30) begin : g_bad_addr
      $error("bytewr_packer: ADDR_W out of range");
   end
   if (LEN_W < LANE_W + 1) begin : g_bad_len
      $error("bytewr_packer: LEN_W too narrow for a word count");
   end
   if (DEV_BYTES < LANES || DEV_BYTES > (1 << ADDR_W)) begin : g_bad_dev
      $error("bytewr_packer: DEV_BYTES does not fit the address space");
   end

   logic              range_empty, range_over;
   logic              fill_clear, fill_wr;
   logic [LANE_W-1:0] fill_lane;

   bwp_range_chk #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)
   ) u_range (
      .addr_i (req_addr),
      .len_i  (req_len),
      .empty_o(range_empty),
      .over_o (range_over)
   );

   bwp_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .range_empty(range_empty),
      .range_over (range_over),
      .in_valid   (in_valid),
      .wrd_ready  (wrd_ready),
      .rsp_valid  (rsp_valid),
      .rsp_fail   (rsp_fail),
      .req_ready  (req_ready),
      .in_ready   (in_ready),
      .wrd_valid  (wrd_valid),
      .wrd_addr   (wrd_addr),
      .fill_clear (fill_clear),
      .fill_wr    (fill_wr),
      .fill_lane  (fill_lane),
      .done       (done),
      .done_err   (done_err),
      .done_count (done_count)
   );

   bwp_lane_fill #(
      .LANES(LANES), .PAD(PAD)
   ) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (fill_clear),
      .wr_en_i  (fill_wr),
      .wr_lane_i(fill_lane),
      .wr_byte_i(in_byte),
      .word_o   (wrd_data)
   );
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
   parameter int ADDR_W = 21,
   parameter int LEN_W  = 16,
   parameter int LANES  = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_ready,
   input logic                 in_ready,
   input logic                 wrd_valid,
   input logic                 wrd_ready,
   input logic [ADDR_W-1:0]    wrd_addr,
   input logic [8*LANES-1:0]   wrd_data,
   input logic                 done,
   input logic [LEN_W-1:0]     done_count
);
   localparam int LANE_W = $clog2(LANES);

   logic              prev_v;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v    <= 1'b0;
         prev_addr <= '0;
      end else if (done) begin
         prev_v    <= 1'b0;
      end else if (wrd_valid && wrd_ready) begin
         prev_v    <= 1'b1;
         prev_addr <= wrd_addr;
      end
   end

   p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrd_valid |-> (wrd_addr[LANE_W-1:0] == '0));

   p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrd_valid && prev_v) |-> (wrd_addr == prev_addr + ADDR_W'(LANES)));

   p_no_byte_in_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wrd_valid |-> !in_ready);

   p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrd_valid && !wrd_ready) |=> (wrd_valid && $stable(wrd_addr) && $stable(wrd_data)));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!in_ready && !wrd_valid && !done));

   p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wrd_valid && !wrd_ready) |=> $stable(done_count));
endmodule

bind bytewr_packer bwp_checker #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .in_ready  (in_ready),
   .wrd_valid (wrd_valid),
   .wrd_ready (wrd_ready),
   .wrd_addr  (wrd_addr),
   .wrd_data  (wrd_data),
   .done      (done),
   .done_count(done_count)
);

// File: tb/sim_bytewr_packer.sv
`timescale 1ns/1ps
module sim_bytewr_packer;
   localparam int AW  = 12;
   localparam int LW  = 10;
   localparam int DEV = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_byte = '0;
   logic          wrd_valid;
   logic          wrd_ready = 1'b0;
   logic [AW-1:0] wrd_addr;
   logic [31:0]   wrd_data;
   logic          rsp_valid = 1'b0;
   logic          rsp_fail = 1'b0;
   logic          done;
   logic          done_err;
   logic [LW-1:0] done_count;

   always #2 clk = ~clk;

   bytewr_packer #(.ADDR_W(AW), .LEN_W(LW), .LANES(4), .DEV_BYTES(DEV)) u0 (.*);

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [7:0]  bq[$];
   int          e_addr[$];
   logic [31:0] e_data[$];
   string       e_tag[$];
   int          e_err, e_cnt, e_cons, fail_at, rsp_lat, rsp_wait, w_idx, cyc;
   bit          busy = 0, got_done = 0, pend_req = 0, stall_en = 0;
   bit          hs_req = 0, hs_in = 0, hs_w = 0, rsp_pend = 0, rsp_fail_nx = 0, prev_done = 0;
   string       res_tag;

   task automatic chk(string tag, longint got, longint exp, string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (hs_req) begin req_valid = 1'b0; busy = 1; end
      if (hs_in) void'(bq.pop_front());
      if (hs_w) begin rsp_pend = 1; rsp_wait = rsp_lat; end
      rsp_valid = 1'b0;
      rsp_fail  = 1'b0;
      if (rsp_pend) begin
         if (rsp_wait == 0) begin
            rsp_valid = 1'b1; rsp_fail = rsp_fail_nx; rsp_pend = 0;
         end else rsp_wait--;
      end
      // per-clock comparison with the model
      chk("R12", req_ready, !busy, "req_ready vs idle");
      if (in_ready && !busy) chk("R8", in_ready, 0, "byte taken while idle");
      if (done && prev_done) chk("R12", 2, 1, "done longer than one cycle");
      if (done) begin
         chk(res_tag, done_err, e_err, "done_err");
         chk(res_tag, done_count, e_cnt, "done_count");
         busy = 0; got_done = 1;
      end
      prev_done = done;
      // drive
      if (pend_req) begin req_valid = 1'b1; pend_req = 0; end
      in_valid  = (bq.size() > 0);
      in_byte   = (bq.size() > 0) ? bq[0] : 8'h00;
      wrd_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
      #1;
      hs_req = req_valid && req_ready;
      hs_in  = in_valid && in_ready;
      hs_w   = wrd_valid && wrd_ready;
      if (hs_w) begin
         if (e_addr.size() == 0) begin
            chk("R11", 1, 0, "unexpected word issued");
         end else begin
            chk("R4", wrd_addr, e_addr[0], "word address");
            chk(e_tag[0], wrd_data, e_data[0], "word data");
            void'(e_addr.pop_front()); void'(e_data.pop_front()); void'(e_tag.pop_front());
         end
         rsp_fail_nx = (w_idx == fail_at);
         w_idx++;
      end
   endtask

   function automatic logic [7:0] bval(int i, int seed);
      return 8'((i * 37) + seed);
   endfunction

   task automatic run_req(int addr, int len, int fail, bit stall, int lat, int seed);
      int pos, idx, w, k, n, wa;
      logic [31:0] d;
      bit head, stop;
      e_err = 0; e_cnt = 0; e_cons = 0;
      if (len == 0) res_tag = "R2";
      else if (addr + len > DEV) begin res_tag = "R3"; e_err = 1; end
      else begin
         res_tag = (fail >= 0) ? "R11" : "R10";
         pos = addr; idx = 0; w = 0; stop = 0;
         while (idx < len && !stop) begin
            wa = pos & ~3; d = '1; k = pos - wa; head = (k != 0); n = 0;
            while (k < 4 && idx < len) begin
               d[8*k +: 8] = bval(idx, seed); k++; idx++; n++;
            end
            e_addr.push_back(wa); e_data.push_back(d);
            e_tag.push_back(head ? "R5" : ((k < 4) ? "R6" : "R7"));
            e_cons += n;
            if (w == fail) begin e_err = 1; stop = 1; end
            else e_cnt += n;
            pos = wa + 4; w++;
         end
      end
      for (int i = 0; i < len; i++) bq.push_back(bval(i, seed));
      fail_at = fail; stall_en = stall; rsp_lat = lat; w_idx = 0; got_done = 0;
      req_addr = AW'(addr); req_len = LW'(len); pend_req = 1;
      while (!got_done) step();
      step();
      chk((res_tag == "R10") ? "R8" : res_tag, len - bq.size(), e_cons, "bytes consumed");
      chk((res_tag == "R10") ? "R10" : res_tag, e_addr.size(), 0, "words left unissued");
      bq.delete(); e_addr.delete(); e_data.delete(); e_tag.delete();
   endtask

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL R10 watchdog: got 0 done expected 1");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", req_ready, 1, "req_ready after reset");
      chk("R1", in_ready, 0, "in_ready after reset");
      chk("R1", wrd_valid, 0, "wrd_valid after reset");
      chk("R1", done, 0, "done after reset");
      run_req(5,    0,  -1, 0, 0, 1);   // R2 zero length
      run_req(16,   12, -1, 0, 0, 2);   // R7 aligned full words
      run_req(33,   10, -1, 0, 1, 3);   // R5 R6 head and tail
      run_req(65,   2,  -1, 0, 0, 4);   // R5 R6 inside one word
      run_req(96,   6,  -1, 1, 2, 5);   // R6 aligned start, tail, stalls
      run_req(259,  1,  -1, 0, 0, 6);   // R5 top lane only
      run_req(1020, 4,  -1, 0, 0, 7);   // R3 boundary: ends at device size
      run_req(1021, 4,  -1, 0, 0, 8);   // R3 one byte past the end
      run_req(2000, 0,  -1, 0, 0, 9);   // R2 zero length beats range check
      run_req(129,  11, 1,  0, 1, 10);  // R11 second word fails
      run_req(200,  9,  0,  1, 0, 11);  // R11 first word fails
      run_req(514,  300, -1, 1, 3, 12); // R9 R10 long run with stalls
      run_req(0,    1023, -1, 0, 0, 13);// R10 maximum length
      summary();
      $finish;
   end
endmodule